// File: doc/BRIEF.md
# Segment Limit and Access-Rights Checker

This block decides whether one memory access may go through a segment whose
descriptor has already been expanded and cached. Each strobe carries the
segment's base, its 32-bit byte limit, its type bits (executable, conforming or
expand-down, readable or writable), its big/default-size bit, and the access:
its kind (read, write or execute), its starting offset and its size in bytes.

One clock after the strobe the block returns a registered verdict: a fault
flag, a two-bit cause code, and, when the access passes, the linear address
formed as base plus offset. Both the first and the last byte of a multi-byte
access are checked. Data segments may grow downward, in which case the valid
window lies strictly above the limit and is capped at 64 KiB or 4 GiB
depending on the big bit. Privilege levels, paging and descriptor fetching lie
outside this block.

Top module: `seg_access_checker`

## Requirements
- R1: A response appears exactly one cycle after a sampled strobe (`rsp_valid` high); a cycle without a strobe gives `rsp_valid` low in the next cycle, and `rsp_fault`, `rsp_cause` and `rsp_linear` keep their previous values.
- R2: While reset is asserted and until the first strobe, `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_linear` are all zero.
- R3: For a code segment (`seg_exec`=1) or an upward data segment (`seg_exec`=0, `seg_ce`=0), the access passes the range test only when its last byte offset is at most `seg_limit`.
- R4: For a downward data segment (`seg_exec`=0, `seg_ce`=1), the access passes the range test only when its first offset is strictly above `seg_limit` and its last offset is at most the upper bound; with limit 0, offset 0 faults and offset 1 passes.
- R5: The downward upper bound is 0x0000FFFF when `seg_big`=0 and 0xFFFFFFFF when `seg_big`=1.
- R6: A write (`acc_kind`=2'b01) to any executable segment faults with the rights cause, whatever the offset.
- R7: A read (`acc_kind`=2'b00) of an executable segment with `seg_rw`=0 faults with the rights cause; with `seg_rw`=1 it is allowed.
- R8: A write to a data segment with `seg_rw`=0 faults with the rights cause; with `seg_rw`=1 it is allowed.
- R9: An execute access (`acc_kind`=2'b10) to a data segment faults with the rights cause, and the reserved kind 2'b11 always faults with the rights cause.
- R10: The last byte offset is `acc_offset + acc_size - 1`, with size 0 counted as one byte; if that sum carries past bit 31 the access faults with the wrap cause.
- R11: `rsp_cause` is 2'b00 pass, 2'b01 rights, 2'b10 range, 2'b11 wrap; when several apply the priority is rights, then wrap, then range; `rsp_fault` is high exactly when the cause is not 2'b00.
- R12: On a passing access `rsp_linear` is `seg_base + acc_offset` modulo 2^32; on a faulting access it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Strobe: the request fields are sampled this cycle |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 32 | Expanded byte limit |
| seg_exec | input | 1 | Segment is executable |
| seg_ce | input | 1 | Conforming (code) or grows downward (data) |
| seg_rw | input | 1 | Readable (code) or writable (data) |
| seg_big | input | 1 | Big bit: selects the downward upper bound |
| acc_kind | input | 2 | 00 read, 01 write, 10 execute, 11 reserved |
| acc_offset | input | 32 | First byte offset of the access |
| acc_size | input | 3 | Access size in bytes (0 counts as 1) |
| rsp_valid | output | 1 | Response for the strobe of the previous cycle |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | Reason code, see R11 |
| rsp_linear | output | 32 | Linear address on pass, zero on fault |

## Verification
Directed vectors place the first and last byte on either side of the limit for upward code and data segments, and on either side of the limit and the 64 KiB or 4 GiB ceiling for downward segments, including the limit-0 pair that separates offset 0 from offset 1. Every pairing of segment type and access kind is tried inside the limit so that rights faults are told apart from range faults, and overlapping faults show the cause priority. Offsets near 0xFFFFFFFF with sizes 0 to 4 separate a carry-out from an ordinary range fault, a base near the top shows address wrap, idle gaps show the held outputs, and a run of random requests cross-checks the rest against the bench's model.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'b00,
        CAUSE_RIGHTS = 2'b01,
        CAUSE_RANGE  = 2'b10,
        CAUSE_WRAP   = 2'b11
    } cause_e;

endpackage

// File: rtl/seg_rights_chk.sv
module seg_rights_chk
    import seg_chk_pkg::*;
(
    input  logic       is_exec,
    input  logic       rw_bit,
    input  logic [1:0] kind,
    output logic       deny
);

    acc_kind_e kind_e;

    always_comb begin
        kind_e = acc_kind_e'(kind);
        deny   = 1'b0;
        unique case (kind_e)
            ACC_READ:  deny = is_exec && !rw_bit;   // execute-only code
            ACC_WRITE: deny = is_exec || !rw_bit;   // code, or read-only data
            ACC_EXEC:  deny = !is_exec;             // data is never fetched
            ACC_RSVD:  deny = 1'b1;
            default:   deny = 1'b1;
        endcase
    end

endmodule

// File: rtl/seg_range_chk.sv
module seg_range_chk #(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 3,
    parameter int NARROW_W = 16
) (
    input  logic [ADDR_W-1:0] limit,
    input  logic [ADDR_W-1:0] offset,
    input  logic [SIZE_W-1:0] size,
    input  logic              grows_down,
    input  logic              big,
    output logic              wrap,
    output logic              out_of_range
);

    localparam int EXT_W = ADDR_W + 1;

    logic [SIZE_W-1:0] span;
    logic [EXT_W-1:0]  last_ext;
    logic [ADDR_W-1:0] last_off;
    logic [ADDR_W-1:0] top_narrow;
    logic [ADDR_W-1:0] top_bound;

    generate
        if (ADDR_W > NARROW_W) begin : g_narrow
            assign top_narrow = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_full
            assign top_narrow = {ADDR_W{1'b1}};
        end
    endgenerate

    always_comb begin
        span      = (size == '0) ? '0 : size - 1'b1;
        last_ext  = {1'b0, offset} + {{(EXT_W-SIZE_W){1'b0}}, span};
        wrap      = last_ext[ADDR_W];
        last_off  = last_ext[ADDR_W-1:0];
        top_bound = big ? {ADDR_W{1'b1}} : top_narrow;
        if (grows_down) begin
            out_of_range = (offset <= limit) || (last_off > top_bound);
        end else begin
            out_of_range = (offset > limit) || (last_off > limit);
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    output logic [ADDR_W-1:0] linear
);

    always_comb begin
        linear = base + offset;
    end

endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int SIZE_W   = 3,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] seg_base,
    input  logic [ADDR_W-1:0] seg_limit,
    input  logic              seg_exec,
    input  logic              seg_ce,
    input  logic              seg_rw,
    input  logic              seg_big,
    input  logic [1:0]        acc_kind,
    input  logic [ADDR_W-1:0] acc_offset,
    input  logic [SIZE_W-1:0] acc_size,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [1:0]        rsp_cause,
    output logic [ADDR_W-1:0] rsp_linear
);

    typedef struct packed {
        logic              vld;
        logic              fault;
        cause_e            cause;
        logic [ADDR_W-1:0] lin;
    } rsp_t;

    rsp_t st_d, st_q;

    logic              deny_w;
    logic              wrap_w;
    logic              range_w;
    logic              grows_down_w;
    logic [ADDR_W-1:0] lin_w;

    assign grows_down_w = !seg_exec && seg_ce;

    seg_rights_chk u_rights (
        .is_exec (seg_exec),
        .rw_bit  (seg_rw),
        .kind    (acc_kind),
        .deny    (deny_w)
    );

    seg_range_chk #(
        .ADDR_W   (ADDR_W),
        .SIZE_W   (SIZE_W),
        .NARROW_W (NARROW_W)
    ) u_range (
        .limit        (seg_limit),
        .offset       (acc_offset),
        .size         (acc_size),
        .grows_down   (grows_down_w),
        .big          (seg_big),
        .wrap         (wrap_w),
        .out_of_range (range_w)
    );

    seg_addr_gen #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .base   (seg_base),
        .offset (acc_offset),
        .linear (lin_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (req_valid) begin
            st_d.vld = 1'b1;
            if (deny_w) begin
                st_d.cause = CAUSE_RIGHTS;
            end else if (wrap_w) begin
                st_d.cause = CAUSE_WRAP;
            end else if (range_w) begin
                st_d.cause = CAUSE_RANGE;
            end else begin
                st_d.cause = CAUSE_NONE;
            end
            st_d.fault = (st_d.cause != CAUSE_NONE);
            st_d.lin   = st_d.fault ? '0 : lin_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, fault: 1'b0, cause: CAUSE_NONE, lin: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid  = st_q.vld;
    assign rsp_fault  = st_q.fault;
    assign rsp_cause  = st_q.cause;
    assign rsp_linear = st_q.lin;

endmodule

// File: rtl/seg_chk_sva.sv
module seg_chk_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              seg_exec,
    input logic              seg_ce,
    input logic              seg_rw,
    input logic [1:0]        acc_kind,
    input logic [ADDR_W-1:0] acc_offset,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [1:0]        rsp_cause,
    input logic [ADDR_W-1:0] rsp_linear
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_fault) && $stable(rsp_cause) && $stable(rsp_linear))); // R1

    AST_CODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_exec && acc_kind == 2'b01) |=> (rsp_fault && rsp_cause == 2'b01)); // R6

    AST_EXEC_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && seg_exec && !seg_rw && acc_kind == 2'b00) |=> (rsp_cause == 2'b01)); // R7

    AST_DATA_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_exec && acc_kind == 2'b10) |=> (rsp_cause == 2'b01)); // R9

    AST_DOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !seg_exec && seg_ce && acc_kind == 2'b00 && acc_offset == '0) |=> rsp_fault); // R4

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 2'b00))); // R11

    AST_LIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_linear == '0)); // R12

endmodule

bind seg_access_checker seg_chk_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/seg_access_checker_tb_top.sv
`timescale 1ns/1ps
module seg_access_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] seg_base = '0, seg_limit = '0, acc_offset = '0;
    logic        seg_exec = 1'b0, seg_ce = 1'b0, seg_rw = 1'b0, seg_big = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic [2:0]  acc_size = '0;
    logic        rsp_valid, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_linear;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model's view of the outputs after the next rising edge
    logic        e_vld = 1'b0, e_fault = 1'b0;
    logic [1:0]  e_cause = 2'b00;
    logic [31:0] e_lin = '0;
    string       e_tag = "R2";

    always #10 clk = ~clk;

    seg_access_checker dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .seg_base(seg_base), .seg_limit(seg_limit), .seg_exec(seg_exec),
        .seg_ce(seg_ce), .seg_rw(seg_rw), .seg_big(seg_big),
        .acc_kind(acc_kind), .acc_offset(acc_offset), .acc_size(acc_size),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause), .rsp_linear(rsp_linear)
    );

    task automatic compare();
        n_cmp++;
        if (rsp_valid !== e_vld || rsp_fault !== e_fault ||
            rsp_cause !== e_cause || rsp_linear !== e_lin) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b fault=%0b cause=%0d lin=%h, want vld=%0b fault=%0b cause=%0d lin=%h",
                     e_tag, rsp_valid, rsp_fault, rsp_cause, rsp_linear,
                     e_vld, e_fault, e_cause, e_lin);
        end
    endtask

    // behavioural reference: cause 1 rights, 3 wrap, 2 range
    task automatic predict(string tag);
        longint unsigned last, lim, off, top;
        int c;
        e_tag = tag;
        if (!req_valid) begin
            e_vld = 1'b0;
            return;
        end
        off  = longint'(acc_offset);
        lim  = longint'(seg_limit);
        last = off + ((acc_size == 0) ? 0 : acc_size - 1);
        top  = seg_big ? 64'hFFFF_FFFF : 64'h0000_FFFF;
        c = 0;
        case (acc_kind)
            2'b00: if (seg_exec && !seg_rw) c = 1;
            2'b01: if (seg_exec || !seg_rw) c = 1;
            2'b10: if (!seg_exec) c = 1;
            default: c = 1;
        endcase
        if (c == 0 && last > 64'hFFFF_FFFF) c = 3;
        if (c == 0) begin
            if (!seg_exec && seg_ce) begin
                if (off <= lim || last > top) c = 2;
            end else if (last > lim) c = 2;
        end
        e_vld   = 1'b1;
        e_cause = c[1:0];
        e_fault = (c != 0);
        e_lin   = (c != 0) ? 32'h0 : seg_base + acc_offset;
    endtask

    task automatic req(string tag, logic [31:0] base, logic [31:0] lim,
                       logic x, logic ce, logic rw, logic big,
                       logic [1:0] kind, logic [31:0] off, logic [2:0] sz);
        @(negedge clk);
        compare();
        req_valid = 1'b1; seg_base = base; seg_limit = lim;
        seg_exec = x; seg_ce = ce; seg_rw = rw; seg_big = big;
        acc_kind = kind; acc_offset = off; acc_size = sz;
        predict(tag);
    endtask

    task automatic idle(string tag);
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        acc_offset = 32'hDEAD_BEEF; acc_kind = 2'b01;
        predict(tag);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang, want completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk) compare();           // R2 during reset
        rst_n = 1'b1;
        idle("R2");
        idle("R2");                                     // R2 after release
        // R3 upward data and code
        req("R3", 32'h1000, 32'h100, 0, 0, 1, 1, 2'b00, 32'h100, 1);
        req("R3", 32'h1000, 32'h100, 0, 0, 1, 1, 2'b00, 32'hFF, 2);
        req("R3", 32'h1000, 32'h100, 0, 0, 1, 1, 2'b00, 32'hFF, 3);
        req("R3", 32'h1000, 32'h100, 1, 0, 0, 0, 2'b10, 32'h101, 1);
        req("R3", 32'h1000, 32'h100, 1, 1, 0, 0, 2'b10, 32'hFD, 4);
        // R4 downward, limit 0 and a larger limit
        req("R4", 32'h0, 32'h0, 0, 1, 1, 1, 2'b00, 32'h0, 1);
        req("R4", 32'h0, 32'h0, 0, 1, 1, 1, 2'b00, 32'h1, 1);
        req("R4", 32'h0, 32'h1000, 0, 1, 1, 1, 2'b01, 32'h1000, 1);
        req("R4", 32'h0, 32'h1000, 0, 1, 1, 1, 2'b01, 32'h1001, 4);
        // R5 ceiling chosen by big bit
        req("R5", 32'h0, 32'h10, 0, 1, 1, 0, 2'b00, 32'hFFFF, 1);
        req("R5", 32'h0, 32'h10, 0, 1, 1, 0, 2'b00, 32'hFFFF, 2);
        req("R5", 32'h0, 32'h10, 0, 1, 1, 0, 2'b00, 32'h10000, 1);
        req("R5", 32'h0, 32'h10, 0, 1, 1, 1, 2'b00, 32'h10000, 1);
        req("R5", 32'h0, 32'h10, 0, 1, 1, 1, 2'b00, 32'hFFFFFFFC, 4);
        // R6 R7 R8 R9 rights
        req("R6", 32'h0, 32'hFFFF, 1, 0, 1, 1, 2'b01, 32'h10, 1);
        req("R7", 32'h0, 32'hFFFF, 1, 0, 0, 1, 2'b00, 32'h10, 1);
        req("R7", 32'h0, 32'hFFFF, 1, 0, 1, 1, 2'b00, 32'h10, 1);
        req("R8", 32'h0, 32'hFFFF, 0, 0, 0, 1, 2'b01, 32'h10, 1);
        req("R8", 32'h0, 32'hFFFF, 0, 0, 1, 1, 2'b01, 32'h10, 1);
        req("R9", 32'h0, 32'hFFFF, 0, 0, 1, 1, 2'b10, 32'h10, 1);
        req("R9", 32'h0, 32'hFFFF, 1, 0, 1, 1, 2'b11, 32'h10, 1);
        // R10 carry-out and size 0
        req("R10", 32'h0, 32'hFFFFFFFF, 0, 0, 1, 1, 2'b00, 32'hFFFFFFFE, 4);
        req("R10", 32'h0, 32'hFFFFFFFF, 0, 0, 1, 1, 2'b00, 32'hFFFFFFFC, 4);
        req("R10", 32'h0, 32'h20, 0, 0, 1, 1, 2'b00, 32'h20, 0);
        // R11 priority
        req("R11", 32'h0, 32'h0, 1, 0, 1, 1, 2'b01, 32'hFFFFFFFF, 4);
        req("R11", 32'h0, 32'h10, 0, 0, 1, 1, 2'b00, 32'hFFFFFFFF, 2);
        // R12 address wrap modulo 2^32
        req("R12", 32'hFFFF0000, 32'hFFFFFFFF, 0, 0, 1, 1, 2'b00, 32'h00020000, 1);
        // R1 idle gap holds last values
        idle("R1");
        idle("R1");
        req("R1", 32'h40, 32'h100, 0, 0, 0, 1, 2'b00, 32'h8, 2);
        idle("R1");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] l, o;
            l = (i % 3 == 0) ? 32'hFFFF : $urandom;
            o = (i % 4 == 0) ? l + ($urandom % 8) - 4 : $urandom;
            req("R3/R4 random", $urandom, l, 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 2'($urandom), o, 3'($urandom % 5));
            if (i % 7 == 0) idle("R1");
        end
        idle("R1");
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule